// File: doc/BRIEF.md
# Programmable Serial Transceiver (USART)

A full-duplex serial transceiver with seven byte-wide registers on an 8-bit bus. Software writes a character into a one-deep transmit holding register; the transmitter moves it into its own shift register and sends a start bit, 7, 8 or 9 data bits (least significant first), an optional parity bit and one or two stop bits. The receiver runs its own frame engine. It places each finished character in a receive holding register and flags framing, parity and overrun problems.

The bit rate comes from a prescaler and a baud divider in cascade, or from rising edges on an external clock pin. In asynchronous mode each bit lasts sixteen ticks and the receiver samples at mid-bit. In synchronous mode a serial clock runs, driven out by the block or taken from the pin. The transmitter changes its line on falling clock edges, and the receiver takes one sample per rising edge. An attention mode lets the receiver drop characters until one arrives with its ninth bit set, which suits address-tagged multi-drop links.

Top module: `sio_usart`

## Requirements
- R1: After reset, CTRL (addr 2) reads 0x01, RSTAT (addr 3) reads 0x00, `tx_out` is 1, and `tx_irq`, `rx_irq` and `sclk_oe` are 0.
- R2: CTRL bits are, from bit 7 down: parity enable, parity select 1, length bit 1 / transmitted ninth bit, parity select 0, length bit 0, error summary, receive full, transmit empty. Bits 7..3 read back as written. Addr 0 writes the transmit data, addr 1 reads the receive data, addr 4 (ICLK) holds sync mode (b7), external clock (b6), two stop bits (b5), receive interrupt enable (b1) and transmit interrupt enable (b0). Addr 5 is the prescaler and addr 6 the baud divider.
- R3: Frame length: length bit 0 = 1 gives 9 data bits, with CTRL bit 5 as the ninth transmitted bit. Otherwise CTRL bit 5 = 1 gives 7 bits and 0 gives 8 bits. A frame is one low start bit, the data bits LSB first, then the stop bits at 1. The line idles at 1.
- R4: When parity is enabled, a parity bit follows the data. Select {psel1,psel0}: 00 odd, 01 even, 10 always 1, 11 always 0.
- R5: ICLK bit 5 = 1 sends two stop bits; 0 sends one.
- R6: The receiver checks the start bit at mid-bit (tick 8 of 16) and samples each later bit every 16 ticks. The character is read at addr 1 (7-bit frames read with bit 7 clear), and the ninth bit is stored in RSTAT bit 4. Reading addr 1 clears receive full.
- R7: A low first stop bit sets RSTAT bit 7 (framing). A parity mismatch sets RSTAT bit 5. CTRL bit 2 is the OR of RSTAT bits 7, 6 and 5. Reading RSTAT clears all three.
- R8: A character that completes while receive full is set raises RSTAT bit 6 (overrun) and leaves the held character unchanged.
- R9: While RSTAT bit 3 (attention, writable) is 1, characters with a clear ninth bit are dropped and receive full stays clear. The first character with its ninth bit set is loaded and clears attention.
- R10: Writing addr 0 clears transmit empty. It sets again when the character moves into the shift register, and RSTAT bit 1 reports a frame being sent.
- R11: `tx_irq` follows transmit-empty AND ICLK bit 0, and `rx_irq` follows receive-full AND ICLK bit 1, each one cycle later.
- R12: With the internal clock in asynchronous mode, one bit lasts 16*(prescaler+1)*(baud+1) clock cycles.
- R13: In synchronous mode with the internal clock, `sclk_oe` is 1 and `sclk_out` toggles on every divider tick. `tx_out` changes only as `sclk_out` falls, and the receiver samples once per rising edge.
- R14: With ICLK bit 6 set in asynchronous mode, each rising edge of `sclk_in` is one tick, so a bit lasts 16 external clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read data registered) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| sclk_in | input | 1 | External clock / synchronous clock input |
| sclk_out | output | 1 | Generated synchronous clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions watch cycle-level invariants on every clock. They check that the line idles high, that a write to the holding register clears the empty flag, that an overrun leaves the held character untouched, and that a dropped attention-mode character changes neither the buffer nor its flag. They also check that a received character only completes out of the stop state and that divider ticks never come back to back when the prescaler is nonzero. Only the bench scenarios can show the serial encodings end to end. These are the bit order across every length, parity, stop-count and data combination, the error flags for corrupted frames, the exact bit durations under the divider and the external clock, and the clock-edge alignment of synchronous loopback traffic.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int MAXD = 9;
  localparam int FRW  = 13;

  function automatic logic [3:0] frame_bits(input logic len0, input logic len1);
    if (len0) return 4'd9;
    else if (len1) return 4'd7;
    else return 4'd8;
  endfunction

  function automatic logic [8:0] width_mask(input logic [3:0] n);
    return 9'h1FF >> (4'd9 - n);
  endfunction

  // sel: 0 odd, 1 even, 2 forced one, 3 forced zero
  function automatic logic parity_bit(input logic [8:0] d, input logic [3:0] n,
                                      input logic [1:0] sel);
    logic x;
    x = ^(d & width_mask(n));
    case (sel)
      2'd0:    return ~x;
      2'd1:    return x;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] presc,
  input  logic [DIV_W-1:0] baud,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      bcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pcnt >= presc) begin
        pcnt <= '0;
        if (bcnt >= baud) begin
          bcnt <= '0;
          tick <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  a_r12_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && presc != '0 && $stable(presc)) |=> !tick);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sync,
  input  logic       start,
  input  logic [8:0] data,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic [1:0] psel,
  input  logic       two_stop,
  output logic       take,
  output logic       busy,
  output logic       txd
);
  localparam int OS_W = $clog2(OSR);

  logic [FRW-1:0]  sh;
  logic [FRW-1:0]  frm;
  logic [3:0]      rem;
  logic [3:0]      flen;
  logic [OS_W-1:0] ocnt;
  logic [OS_W-1:0] lim;

  assign lim = sync ? '0 : OS_W'(OSR - 1);

  always_comb begin
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < MAXD; i++) begin
      if (i < int'(nbits)) frm[i+1] = data[i];
    end
    if (par_en) frm[nbits + 4'd1] = parity_bit(data, nbits, psel);
    flen = 4'd2 + nbits + {3'b000, par_en} + {3'b000, two_stop};
  end

  assign take = start && !busy && (!sync || tick);
  assign txd  = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      busy <= 1'b0;
      rem  <= '0;
      ocnt <= '0;
    end else if (take) begin
      sh   <= frm;
      rem  <= flen;
      busy <= 1'b1;
      ocnt <= '0;
    end else if (busy && tick) begin
      if (ocnt == lim) begin
        ocnt <= '0;
        sh   <= {1'b1, sh[FRW-1:1]};
        rem  <= rem - 1'b1;
        if (rem == 4'd1) busy <= 1'b0;
      end else begin
        ocnt <= ocnt + 1'b1;
      end
    end
  end

  a_r3_idle_mark: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  a_r3_len_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> rem != 4'd0);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sync,
  input  logic       rxd,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic [1:0] psel,
  output logic       done,
  output logic [8:0] data,
  output logic       ferr,
  output logic       perr,
  output logic       busy
);
  localparam int OS_W = $clog2(OSR);
  localparam logic [OS_W-1:0] MID = OS_W'(OSR / 2 - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_e;

  rx_st_e          st;
  logic [OS_W-1:0] ocnt;
  logic [OS_W-1:0] lim;
  logic [3:0]      bidx;
  logic [3:0]      payload;
  logic [9:0]      frm;

  assign lim     = sync ? '0 : OS_W'(OSR - 1);
  assign payload = nbits + {3'b000, par_en};
  assign busy    = (st != R_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= R_IDLE;
      ocnt <= '0;
      bidx <= '0;
      frm  <= '0;
      done <= 1'b0;
      data <= '0;
      ferr <= 1'b0;
      perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          R_IDLE: if (!rxd) begin
            ocnt <= '0;
            bidx <= '0;
            st   <= sync ? R_DATA : R_START;
          end
          R_START: if (ocnt == MID) begin
            ocnt <= '0;
            st   <= rxd ? R_IDLE : R_DATA;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
          R_DATA: if (ocnt == lim) begin
            ocnt      <= '0;
            frm[bidx] <= rxd;
            bidx      <= bidx + 1'b1;
            if (bidx == payload - 4'd1) st <= R_STOP;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
          default: if (ocnt == lim) begin
            ocnt <= '0;
            st   <= R_IDLE;
            done <= 1'b1;
            ferr <= !rxd;
            data <= frm[8:0] & width_mask(nbits);
            perr <= par_en && (frm[nbits] != parity_bit(frm[8:0], nbits, psel));
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        endcase
      end
    end
  end

  a_r6_done_from_stop: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == R_STOP);
  a_r6_index_bound: assert property (@(posedge clk) disable iff (rst)
    (st == R_DATA) |-> bidx <= 4'd10);
endmodule

// File: rtl/sio_usart.sv
module sio_usart
  import sio_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_in,
  output logic       tx_out,
  input  logic       sclk_in,
  output logic       sclk_out,
  output logic       sclk_oe,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam int DW = 8;
  localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_CTRL = 3'd2, A_RSTAT = 3'd3,
                         A_ICLK = 3'd4, A_PRE = 3'd5, A_BAUD = 3'd6;

  // configuration
  logic          par_en, psel1, len1x, psel0, len0;
  logic          sync_md, ext_clk, two_stop, rx_ie, tx_ie;
  logic [DW-1:0] presc, baud;
  // buffers and status
  logic [DW-1:0] tbuf, rbuf;
  logic          tbfull, rbfull, rbit9, fe, oe, pe, attn;

  logic [3:0] nbits;
  logic [1:0] psel;
  assign nbits = frame_bits(len0, len1x);
  assign psel  = {psel1, psel0};

  // input synchronizers
  logic [SYNC_STAGES-1:0] rx_pipe;
  logic [SYNC_STAGES:0]   sc_pipe;
  logic rx_s, ext_rise, ext_fall;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          rx_pipe <= '1;
          sc_pipe <= '1;
        end else begin
          rx_pipe <= {rx_pipe[SYNC_STAGES-2:0], rx_in};
          sc_pipe <= {sc_pipe[SYNC_STAGES-1:0], sclk_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          rx_pipe <= '1;
          sc_pipe <= '1;
        end else begin
          rx_pipe <= rx_in;
          sc_pipe <= {sc_pipe[SYNC_STAGES-1:0], sclk_in};
        end
      end
    end
  endgenerate

  assign rx_s     = rx_pipe[SYNC_STAGES-1];
  assign ext_rise = sc_pipe[SYNC_STAGES-1] & ~sc_pipe[SYNC_STAGES];
  assign ext_fall = ~sc_pipe[SYNC_STAGES-1] & sc_pipe[SYNC_STAGES];

  // tick generation
  logic div_tick, sync_int, sclk_q, int_rise, int_fall, os_tick, tx_tick, rx_tick;

  sio_baud #(.DIV_W(DW)) u_baud (
    .clk(clk), .rst(rst), .presc(presc), .baud(baud), .tick(div_tick)
  );

  assign sync_int = sync_md & ~ext_clk;
  assign int_fall = sync_int & div_tick & sclk_q;
  assign int_rise = sync_int & div_tick & ~sclk_q;
  assign os_tick  = ext_clk ? ext_rise : div_tick;
  assign tx_tick  = sync_md ? (ext_clk ? ext_fall : int_fall) : os_tick;
  assign rx_tick  = sync_md ? (ext_clk ? ext_rise : int_rise) : os_tick;

  always_ff @(posedge clk) begin
    if (rst)           sclk_q <= 1'b1;
    else if (!sync_int) sclk_q <= 1'b1;
    else if (div_tick) sclk_q <= ~sclk_q;
  end
  assign sclk_out = sclk_q;

  // transmitter
  logic tx_take, tx_busy;
  sio_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .sync(sync_md), .start(tbfull),
    .data({len0 & len1x, tbuf}), .nbits(nbits), .par_en(par_en), .psel(psel),
    .two_stop(two_stop), .take(tx_take), .busy(tx_busy), .txd(tx_out)
  );

  // receiver
  logic       rx_done, rx_fe, rx_pe, rx_busy, rx_accept;
  logic [8:0] rx_data;
  sio_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .sync(sync_md), .rxd(rx_s),
    .nbits(nbits), .par_en(par_en), .psel(psel), .done(rx_done),
    .data(rx_data), .ferr(rx_fe), .perr(rx_pe), .busy(rx_busy)
  );
  assign rx_accept = !attn || rx_data[8];

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (addr)
      A_RXD:   rd_mux = rbuf;
      A_CTRL:  rd_mux = {par_en, psel1, len1x, psel0, len0, fe | oe | pe, rbfull, ~tbfull};
      A_RSTAT: rd_mux = {fe, oe, pe, rbit9, attn, rx_busy, tx_busy, 1'b0};
      A_ICLK:  rd_mux = {sync_md, ext_clk, two_stop, 3'b000, rx_ie, tx_ie};
      A_PRE:   rd_mux = presc;
      A_BAUD:  rd_mux = baud;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {par_en, psel1, len1x, psel0, len0} <= '0;
      {sync_md, ext_clk, two_stop, rx_ie, tx_ie} <= '0;
      presc   <= '0;
      baud    <= '0;
      tbuf    <= '0;
      rbuf    <= '0;
      tbfull  <= 1'b0;
      rbfull  <= 1'b0;
      rbit9   <= 1'b0;
      fe      <= 1'b0;
      oe      <= 1'b0;
      pe      <= 1'b0;
      attn    <= 1'b0;
      rdata   <= '0;
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
      sclk_oe <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_TXD:   tbuf <= wdata;
          A_CTRL:  {par_en, psel1, len1x, psel0, len0} <= wdata[7:3];
          A_RSTAT: attn <= wdata[3];
          A_ICLK:  {sync_md, ext_clk, two_stop, rx_ie, tx_ie} <=
                     {wdata[7:5], wdata[1:0]};
          A_PRE:   presc <= wdata;
          A_BAUD:  baud <= wdata;
          default: ;
        endcase
      end
      if (tx_take) tbfull <= 1'b0;
      if (wr_en && addr == A_TXD) tbfull <= 1'b1;
      if (rd_en && addr == A_RXD) rbfull <= 1'b0;
      if (rd_en && addr == A_RSTAT) {fe, oe, pe} <= 3'b000;
      if (rx_done && rx_accept) begin
        if (attn) attn <= 1'b0;
        if (rbfull) begin
          oe <= 1'b1;
        end else begin
          rbuf   <= rx_data[7:0];
          rbit9  <= rx_data[8];
          rbfull <= 1'b1;
          fe     <= fe | rx_fe;
          pe     <= pe | rx_pe;
        end
      end
      if (rd_en) rdata <= rd_mux;
      tx_irq  <= tx_ie & ~tbfull;
      rx_irq  <= rx_ie & rbfull;
      sclk_oe <= sync_int;
    end
  end

  a_r10_write_fills: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_TXD) |=> tbfull);
  a_r8_overrun_holds: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_accept && rbfull) |=> (oe && $stable(rbuf)));
  a_r9_attn_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_done && attn && !rx_data[8] && !(rd_en && addr == A_RXD))
      |=> ($stable(rbuf) && $stable(rbfull)));
  a_r11_rx_irq_src: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(rbfull));
endmodule

// File: tb/sio_usart_bench.sv
module sio_usart_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_drv = 1'b1, loop = 1'b0;
  logic       rx_line, tx_out, sclk_in = 1'b1, sclk_out, sclk_oe, tx_irq, rx_irq;
  logic       sclk_run = 1'b0;
  logic [1:0] sc_div = '0;
  logic       mon_en = 1'b0, prev_tx = 1'b1, prev_sc = 1'b1;
  int         sync_bad = 0;
  int         checks = 0, errors = 0, cycles = 0;

  assign rx_line = loop ? tx_out : rx_drv;

  sio_usart u_sio_usart (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_in(rx_line), .tx_out(tx_out),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (sclk_run) begin
      sc_div <= sc_div + 2'd1;
      if (sc_div[0]) sclk_in <= ~sclk_in;
    end
    if (mon_en && tx_out != prev_tx && !(sclk_out == 1'b0 && prev_sc == 1'b1))
      sync_bad <= sync_bad + 1;
    prev_tx <= tx_out;
    prev_sc <= sclk_out;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic logic [12:0] efrm(input logic [8:0] d, input int nd, input bit pen,
                                       input int ps, input bit two, output int len);
    logic [12:0] f;
    int ones;
    f = '1; f[0] = 1'b0; ones = 0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (pen) f[nd+1] = (ps == 0) ? ~ones[0] : (ps == 1) ? ones[0] : (ps == 2);
    len = 2 + nd + int'(pen) + int'(two);
    return f;
  endfunction

  function automatic logic [7:0] ctrl_of(input int nd, input bit pen, input int ps,
                                         input bit x9);
    logic [1:0] p;
    p = ps[1:0];
    return {pen, p[1], (nd == 7) || (nd == 9 && x9), p[0], nd == 9, 3'b000};
  endfunction

  task automatic cap(input int len, input int bitclk, output logic [12:0] v);
    v = '1;
    while (tx_out !== 1'b0) @(negedge clk);
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      v[i] = tx_out;
      repeat (bitclk) @(negedge clk);
    end
  endtask

  task automatic send(input logic [12:0] v, input int len, input int bitclk);
    for (int i = 0; i < len; i++) begin
      rx_drv = v[i];
      repeat (bitclk) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (bitclk * 2) @(negedge clk);
  endtask

  task automatic high_len(output int n);
    n = 0;
    while (tx_out !== 1'b0) @(negedge clk);
    while (tx_out !== 1'b1) @(negedge clk);
    while (tx_out === 1'b1) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    logic [7:0]  r;
    logic [12:0] v, e;
    int          len, n;
    logic [8:0]  dv [3];
    dv[0] = 9'h000; dv[1] = 9'h1A5; dv[2] = 9'h05A;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(3'd2, r); chk("R1 ctrl reset", r, 8'h01);
    rd(3'd3, r); chk("R1 rstat reset", r, 8'h00);
    chk("R1 line/irq/oe", {tx_out, tx_irq, rx_irq, sclk_oe}, 4'b1000);

    // R2 register layout
    wr(3'd2, 8'hF8); rd(3'd2, r); chk("R2 ctrl readback", r, 8'hF9);
    wr(3'd4, 8'hE3); rd(3'd4, r); chk("R2 iclk readback", r, 8'hE3);
    wr(3'd5, 8'h5C); rd(3'd5, r); chk("R2 prescaler readback", r, 8'h5C);
    wr(3'd4, 8'h00); wr(3'd2, 8'h00); wr(3'd5, 8'h00);

    // R3 R4 R5 transmit sweep
    for (int nd = 7; nd <= 9; nd++)
      for (int pm = 0; pm < 5; pm++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 3; k++) begin
            wr(3'd4, st ? 8'h20 : 8'h00);
            wr(3'd2, ctrl_of(nd, pm != 0, (pm == 0) ? 0 : pm - 1, dv[k][8]));
            e = efrm(dv[k], nd, pm != 0, (pm == 0) ? 0 : pm - 1, st != 0, len);
            wr(3'd0, dv[k][7:0]);
            cap(len, 16, v);
            chk($sformatf("R3 R4 R5 tx frame nd=%0d pm=%0d st=%0d", nd, pm, st), {3'b0, v},
                {3'b0, e});
            repeat (12) @(negedge clk);
          end
    wr(3'd4, 8'h00);

    // R6 R4 receive sweep
    for (int nd = 7; nd <= 9; nd++)
      for (int pm = 0; pm < 3; pm++)
        for (int k = 1; k < 3; k++) begin
          wr(3'd2, ctrl_of(nd, pm != 0, (pm == 0) ? 0 : pm - 1, 1'b0));
          e = efrm(dv[k], nd, pm != 0, (pm == 0) ? 0 : pm - 1, 1'b0, len);
          send(e, len, 16);
          rd(3'd1, r);
          chk($sformatf("R6 rx data nd=%0d pm=%0d", nd, pm), r,
              (nd == 7) ? {1'b0, dv[k][6:0]} : dv[k][7:0]);
          rd(3'd3, r);
          chk("R6 rx status ninth bit", r, {3'b000, (nd == 9) && dv[k][8], 4'b0000});
          rd(3'd2, r);
          chk("R6 read clears full", r[1], 1'b0);
        end

    // R7 framing error
    wr(3'd2, 8'h00);
    e = efrm(9'h0C3, 8, 1'b0, 0, 1'b0, len);
    e[len-1] = 1'b0;
    send(e, len, 16);
    rd(3'd2, r); chk("R7 error summary", r[2:1], 2'b11);
    rd(3'd3, r); chk("R7 framing flag", r[7:5], 3'b100);
    rd(3'd3, r); chk("R7 read clears flags", r[7:5], 3'b000);
    rd(3'd1, r); chk("R7 data kept", r, 8'hC3);
    // R7 parity error (even parity, flipped)
    wr(3'd2, 8'h90);
    e = efrm(9'h031, 8, 1'b1, 1, 1'b0, len);
    e[9] = ~e[9];
    send(e, len, 16);
    rd(3'd3, r); chk("R7 parity flag", r[7:5], 3'b001);
    rd(3'd1, r);

    // R8 overrun
    wr(3'd2, 8'h00);
    e = efrm(9'h011, 8, 1'b0, 0, 1'b0, len); send(e, len, 16);
    e = efrm(9'h0EE, 8, 1'b0, 0, 1'b0, len); send(e, len, 16);
    rd(3'd3, r); chk("R8 overrun flag", r[7:5], 3'b010);
    rd(3'd1, r); chk("R8 first char kept", r, 8'h11);

    // R9 attention mode (9-bit frames)
    wr(3'd2, 8'h08);
    wr(3'd3, 8'h08);
    rd(3'd3, r); chk("R9 attention set", r[3], 1'b1);
    e = efrm(9'h033, 9, 1'b0, 0, 1'b0, len); send(e, len, 16);
    rd(3'd2, r); chk("R9 dropped char leaves full clear", r[1], 1'b0);
    e = efrm(9'h17E, 9, 1'b0, 0, 1'b0, len); send(e, len, 16);
    rd(3'd3, r); chk("R9 marked char: ninth set, attention cleared", r[4:3], 2'b10);
    rd(3'd1, r); chk("R9 marked char data", r, 8'h7E);
    e = efrm(9'h011, 9, 1'b0, 0, 1'b0, len); send(e, len, 16);
    rd(3'd1, r); chk("R9 later unmarked char accepted", r, 8'h11);

    // R10 R11 buffer empty flag and interrupts
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h03);
    repeat (3) @(negedge clk);
    chk("R11 tx irq when empty", tx_irq, 1'b1);
    wr(3'd0, 8'h41);
    wr(3'd0, 8'h42);
    rd(3'd2, r); chk("R10 empty cleared while held", r[0], 1'b0);
    rd(3'd3, r); chk("R10 tx busy", r[1], 1'b1);
    chk("R11 tx irq low while full", tx_irq, 1'b0);
    repeat (200) @(negedge clk);
    rd(3'd2, r); chk("R10 empty after move to shifter", r[0], 1'b1);
    chk("R11 tx irq returns", tx_irq, 1'b1);
    repeat (220) @(negedge clk);
    e = efrm(9'h05A, 8, 1'b0, 0, 1'b0, len); send(e, len, 16);
    chk("R11 rx irq on full", rx_irq, 1'b1);
    rd(3'd1, r);
    repeat (2) @(negedge clk);
    chk("R11 rx irq clears", rx_irq, 1'b0);
    wr(3'd4, 8'h00);

    // R12 divider bit time: 16*2*3 = 96
    loop = 1'b1;
    wr(3'd5, 8'h01); wr(3'd6, 8'h02);
    wr(3'd0, 8'h02);
    high_len(n); chk("R12 bit time", n[15:0], 16'd96);
    repeat (1000) @(negedge clk);
    rd(3'd1, r); chk("R12 loopback data", r, 8'h02);
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);

    // R13 synchronous internal clock
    wr(3'd5, 8'h03);
    wr(3'd4, 8'h80);
    repeat (20) @(negedge clk);
    chk("R13 clock drive enable", sclk_oe, 1'b1);
    mon_en = 1'b1;
    wr(3'd0, 8'h96);
    repeat (200) @(negedge clk);
    mon_en = 1'b0;
    chk("R13 tx edges on sclk fall", sync_bad[15:0], 16'd0);
    rd(3'd1, r); chk("R13 sync loopback data", r, 8'h96);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);

    // R14 external clock, asynchronous
    sclk_run = 1'b1;
    wr(3'd4, 8'h40);
    repeat (40) @(negedge clk);
    rd(3'd3, r);
    wr(3'd0, 8'h02);
    high_len(n); chk("R14 ext bit time", n[15:0], 16'd64);
    repeat (700) @(negedge clk);
    rd(3'd1, r); chk("R14 ext loopback data", r, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule